// File: doc/BRIEF.md
# Event and Interrupt Control Register Bank

This block is the host-visible register bank of a network controller. The host sees a set of configuration registers, which hold interrupt-enable bits and a few trigger bits. It also sees event registers that hardware fills and a host read empties, a live status word, and two saturating counters that track dropped receive frames and transmit collisions. All host access goes through one synchronous port. A read returns its data one cycle after the request and clears the register it hits, if that register is of a clearing kind.

On the hardware side, the receive, transmit and buffer logic pulse per-bit event strobes, and two count strobes feed the counters. The bank drives four single-cycle action pulses, which come from trigger bits that always read back as zero, and one level interrupt request. The request is high while any pending event has its enable set.

Top module: `evtirq_regbank`

## Requirements
- R1: Addresses 0 (receive config), 1 (transmit config), 2 (buffer config), 3 (self control) and 4 (bus control) are read/write. A read returns the last written value, except that bit 6 of addresses 0, 2, 3 and 4 always reads 0.
- R2: Addresses 5 (receive events), 6 (transmit events) and 7 (buffer events) set a bit whenever the matching strobe bit is high, whatever the enables hold. A read returns the value held before that cycle's edge and clears the register.
- R3: An event strobe that arrives in the same cycle as a clearing read of its register survives the clear, and the next read shows it.
- R4: irq_o is high exactly when some event bit is set and bit i of the matching enable register (receive events with address 0, transmit with 1, buffer with 2) is also set. It follows the held state in the same cycle.
- R5: Writing a 1 to bit 6 at address 0, 3, 4 or 2 raises skip_pulse_o, soft_rst_pulse_o, dma_rst_pulse_o or sw_irq_pulse_o respectively, for exactly the one cycle after the write.
- R6: Address 8 returns status_i as sampled in the read cycle. Host writes to addresses 5 to 10 change nothing.
- R7: Address 9 counts miss_inc_i strobes and address 10 counts coll_inc_i strobes. Each counter stops at its all-ones value and is cleared by a host read.
- R8: A count strobe in the same cycle as a clearing read leaves that counter at 1.
- R9: After reset every register, output and pulse is 0. Addresses 11 to 15 read as 0, and host_rdata_o is 0 in every cycle that follows a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_wr_i | input | 1 | Host write request |
| host_rd_i | input | 1 | Host read request |
| host_addr_i | input | AW | Register address |
| host_wdata_i | input | DW | Write data |
| host_rdata_o | output | DW | Read data, valid the cycle after a read |
| rx_evt_i | input | DW | Receive event strobes |
| tx_evt_i | input | DW | Transmit event strobes |
| buf_evt_i | input | DW | Buffer event strobes |
| status_i | input | SW | Live hardware status |
| miss_inc_i | input | 1 | Missed-frame count strobe |
| coll_inc_i | input | 1 | Collision count strobe |
| skip_pulse_o | output | 1 | Skip-frame action pulse |
| soft_rst_pulse_o | output | 1 | Soft reset action pulse |
| dma_rst_pulse_o | output | 1 | Receive DMA reset action pulse |
| sw_irq_pulse_o | output | 1 | Software interrupt action pulse |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted event bit shows on irq_o in the same cycle when its enable is set. Otherwise it shows in the read data the cycle after the next read of that register. A counter that wraps or misses a clear shows on the next read of that counter, and that read can be thousands of cycles away. For that reason the bench drives a counter into saturation with a directed run. A lost merge between a strobe and a clearing read stays hidden until the following read, so the bench pairs those reads back to back.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
   localparam int unsigned ACT_BIT  = 6;
   localparam int unsigned N_CFG    = 5;
   localparam int unsigned N_EVT    = 3;
   localparam int unsigned N_CNT    = 2;
   localparam int unsigned N_ACT    = 4;
   localparam int unsigned ADR_CFG0 = 0;
   localparam int unsigned ADR_EVT0 = 5;
   localparam int unsigned ADR_STAT = 8;
   localparam int unsigned ADR_CNT0 = 9;
   localparam int unsigned ADR_USED = ADR_CNT0 + N_CNT;
   // config slots carrying a trigger bit: rx cfg, buf cfg, self ctl, bus ctl
   localparam logic [N_CFG-1:0] CFG_HAS_ACT = 5'b11101;

   // pulse index -> config slot: skip, soft reset, dma reset, sw irq
   function automatic int unsigned act_slot(input int unsigned i);
      case (i)
         0:       return 0;
         1:       return 3;
         2:       return 4;
         default: return 2;
      endcase
   endfunction
endpackage

// File: rtl/regbank_evt.sv
module regbank_evt #(
   parameter int unsigned DW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic [DW-1:0] set_i,
   input  logic          clr_i,
   input  logic [DW-1:0] enable_i,
   output logic [DW-1:0] evt_o,
   output logic          pend_o
);
   logic [DW-1:0] evt_q;

   // a strobe in the clearing cycle wins over the clear
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) evt_q <= '0;
      else         evt_q <= (clr_i ? '0 : evt_q) | set_i;
   end

   assign evt_o  = evt_q;
   assign pend_o = |(evt_q & enable_i);
endmodule

// File: rtl/regbank_satcnt.sv
module regbank_satcnt #(
   parameter int unsigned CW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          inc_i,
   input  logic          clr_i,
   output logic [CW-1:0] cnt_o
);
   localparam logic [CW-1:0] CNT_MAX = '1;
   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                       cnt_q <= '0;
      else if (clr_i)                    cnt_q <= inc_i ? CW'(1) : '0;
      else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
   end

   assign cnt_o = cnt_q;
endmodule

// File: rtl/evtirq_regbank.sv
module evtirq_regbank
   import regbank_pkg::*;
#(
   parameter int unsigned DW = 16,
   parameter int unsigned AW = 4,
   parameter int unsigned SW = 16,
   parameter int unsigned CW = 16
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          host_wr_i,
   input  logic          host_rd_i,
   input  logic [AW-1:0] host_addr_i,
   input  logic [DW-1:0] host_wdata_i,
   output logic [DW-1:0] host_rdata_o,
   input  logic [DW-1:0] rx_evt_i,
   input  logic [DW-1:0] tx_evt_i,
   input  logic [DW-1:0] buf_evt_i,
   input  logic [SW-1:0] status_i,
   input  logic          miss_inc_i,
   input  logic          coll_inc_i,
   output logic          skip_pulse_o,
   output logic          soft_rst_pulse_o,
   output logic          dma_rst_pulse_o,
   output logic          sw_irq_pulse_o,
   output logic          irq_o
);
   localparam logic [DW-1:0] ACT_MASK = DW'(1) << ACT_BIT;

   if (DW <= ACT_BIT) begin : g_bad_dw
      $error("DW must exceed the trigger bit position");
   end
   if (SW > DW || CW > DW) begin : g_bad_w
      $error("status and counter widths must fit in DW");
   end
   if ((1 << AW) < ADR_USED) begin : g_bad_aw
      $error("AW too small for the register map");
   end

   function automatic logic [DW-1:0] keep_mask(input int unsigned g);
      return CFG_HAS_ACT[g] ? ~ACT_MASK : '1;
   endfunction

   // configuration registers
   logic [N_CFG-1:0][DW-1:0] cfg_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q <= '0;
      else begin
         for (int g = 0; g < int'(N_CFG); g++) begin
            if (host_wr_i && host_addr_i == AW'(ADR_CFG0 + g))
               cfg_q[g] <= host_wdata_i & keep_mask(g);
         end
      end
   end

   // trigger pulses
   logic [N_ACT-1:0] act_d, act_q;
   always_comb begin
      for (int a = 0; a < int'(N_ACT); a++)
         act_d[a] = host_wr_i && host_wdata_i[ACT_BIT] &&
                    (host_addr_i == AW'(act_slot(a)));
   end
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) act_q <= '0;
      else         act_q <= act_d;
   end
   assign skip_pulse_o     = act_q[0];
   assign soft_rst_pulse_o = act_q[1];
   assign dma_rst_pulse_o  = act_q[2];
   assign sw_irq_pulse_o   = act_q[3];

   // event registers
   logic [DW-1:0]    evt_set [N_EVT];
   logic [DW-1:0]    evt_q   [N_EVT];
   logic [N_EVT-1:0] pend;
   assign evt_set[0] = rx_evt_i;
   assign evt_set[1] = tx_evt_i;
   assign evt_set[2] = buf_evt_i;

   for (genvar k = 0; k < N_EVT; k++) begin : g_evt
      logic clr;
      assign clr = host_rd_i && (host_addr_i == AW'(ADR_EVT0 + k));
      regbank_evt #(.DW(DW)) evt_i (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .set_i    (evt_set[k]),
         .clr_i    (clr),
         .enable_i (cfg_q[k]),
         .evt_o    (evt_q[k]),
         .pend_o   (pend[k])
      );
   end
   assign irq_o = |pend;

   // counters
   logic          cnt_inc [N_CNT];
   logic [CW-1:0] cnt_q   [N_CNT];
   assign cnt_inc[0] = miss_inc_i;
   assign cnt_inc[1] = coll_inc_i;

   for (genvar c = 0; c < N_CNT; c++) begin : g_cnt
      logic clr;
      assign clr = host_rd_i && (host_addr_i == AW'(ADR_CNT0 + c));
      regbank_satcnt #(.CW(CW)) cnt_i (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .inc_i  (cnt_inc[c]),
         .clr_i  (clr),
         .cnt_o  (cnt_q[c])
      );
   end

   // read path
   logic [DW-1:0] rd_val;
   always_comb begin
      rd_val = '0;
      for (int g = 0; g < int'(N_CFG); g++)
         if (host_addr_i == AW'(ADR_CFG0 + g)) rd_val = cfg_q[g];
      for (int k = 0; k < int'(N_EVT); k++)
         if (host_addr_i == AW'(ADR_EVT0 + k)) rd_val = evt_q[k];
      if (host_addr_i == AW'(ADR_STAT)) rd_val = DW'(status_i);
      for (int c = 0; c < int'(N_CNT); c++)
         if (host_addr_i == AW'(ADR_CNT0 + c)) rd_val = DW'(cnt_q[c]);
   end

   logic [DW-1:0] rdata_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) rdata_q <= '0;
      else         rdata_q <= host_rd_i ? rd_val : '0;
   end
   assign host_rdata_o = rdata_q;
endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
   import regbank_pkg::*;
#(
   parameter int unsigned DW = 16,
   parameter int unsigned AW = 4,
   parameter int unsigned SW = 16
) (
   input logic          clk_i,
   input logic          rst_ni,
   input logic          host_wr_i,
   input logic          host_rd_i,
   input logic [AW-1:0] host_addr_i,
   input logic [DW-1:0] host_wdata_i,
   input logic [DW-1:0] host_rdata_o,
   input logic [DW-1:0] rx_evt_i,
   input logic [DW-1:0] tx_evt_i,
   input logic [DW-1:0] buf_evt_i,
   input logic [SW-1:0] status_i,
   input logic          miss_inc_i,
   input logic          skip_pulse_o,
   input logic          soft_rst_pulse_o,
   input logic          irq_o
);
   logic any_strobe;
   assign any_strobe = |{rx_evt_i, tx_evt_i, buf_evt_i};

   AST_SKIP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      skip_pulse_o |-> $past(host_wr_i && host_wdata_i[ACT_BIT] && host_addr_i == AW'(0))); // R5
   AST_SOFTRST_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      soft_rst_pulse_o |-> $past(host_wr_i && host_wdata_i[ACT_BIT] && host_addr_i == AW'(3))); // R5
   AST_CFG_TRIG_READS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_rd_i && host_addr_i == AW'(0)) |=> !host_rdata_o[ACT_BIT]); // R1
   AST_STATUS_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_rd_i && host_addr_i == AW'(ADR_STAT)) |=> host_rdata_o == DW'($past(status_i))); // R6
   AST_MISS_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_rd_i && host_addr_i == AW'(ADR_CNT0) && !miss_inc_i) ##1
      (host_rd_i && host_addr_i == AW'(ADR_CNT0)) |=> host_rdata_o == '0); // R7
   AST_IRQ_RISE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_o) |-> $past(host_wr_i || any_strobe)); // R4
   AST_IRQ_STAYS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!irq_o && !host_wr_i && !any_strobe) |=> !irq_o); // R4
   AST_IDLE_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !host_rd_i |=> host_rdata_o == '0); // R9
endmodule

bind evtirq_regbank regbank_chk #(.DW(DW), .AW(AW), .SW(SW)) chk_i (
   .clk_i            (clk_i),
   .rst_ni           (rst_ni),
   .host_wr_i        (host_wr_i),
   .host_rd_i        (host_rd_i),
   .host_addr_i      (host_addr_i),
   .host_wdata_i     (host_wdata_i),
   .host_rdata_o     (host_rdata_o),
   .rx_evt_i         (rx_evt_i),
   .tx_evt_i         (tx_evt_i),
   .buf_evt_i        (buf_evt_i),
   .status_i         (status_i),
   .miss_inc_i       (miss_inc_i),
   .skip_pulse_o     (skip_pulse_o),
   .soft_rst_pulse_o (soft_rst_pulse_o),
   .irq_o            (irq_o)
);

// File: tb/evtirq_regbank_tb.sv
`timescale 1ns/1ps
module evtirq_regbank_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [3:0]  addr = '0;
   logic [15:0] wdata = '0, rdata;
   logic [15:0] rx_s = '0, tx_s = '0, bf_s = '0, st = '0;
   logic        mi = 1'b0, ci = 1'b0;
   logic        p_skip, p_srst, p_dma, p_swi, irq;

   int n_chk = 0, n_fail = 0;

   logic [15:0] m_cfg [5];
   logic [15:0] m_evt [3];
   logic [15:0] m_cnt [2];

   always #10 clk = ~clk;

   evtirq_regbank dut_i (
      .clk_i(clk), .rst_ni(rst_n), .host_wr_i(wr), .host_rd_i(rd),
      .host_addr_i(addr), .host_wdata_i(wdata), .host_rdata_o(rdata),
      .rx_evt_i(rx_s), .tx_evt_i(tx_s), .buf_evt_i(bf_s), .status_i(st),
      .miss_inc_i(mi), .coll_inc_i(ci),
      .skip_pulse_o(p_skip), .soft_rst_pulse_o(p_srst),
      .dma_rst_pulse_o(p_dma), .sw_irq_pulse_o(p_swi), .irq_o(irq)
   );

   task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] m_read(input logic [3:0] a, input logic [15:0] s);
      if (a <= 4)       return m_cfg[a];
      else if (a <= 7)  return m_evt[a - 5];
      else if (a == 8)  return s;
      else if (a <= 10) return m_cnt[a - 9];
      return 16'h0;
   endfunction

   function automatic string rd_tag(input logic [3:0] a);
      if (a <= 4)       return "R1 cfg read";
      else if (a <= 7)  return "R2 event read";
      else if (a == 8)  return "R6 status read";
      else if (a <= 10) return "R7 counter read";
      return "R9 unmapped read";
   endfunction

   function automatic logic m_irq();
      return |((m_evt[0] & m_cfg[0]) | (m_evt[1] & m_cfg[1]) | (m_evt[2] & m_cfg[2]));
   endfunction

   // one cycle: drive at negedge, update model, check after the edge
   task automatic step(input logic w, input logic r, input logic [3:0] a, input logic [15:0] d,
                       input logic [15:0] rxv, input logic [15:0] txv, input logic [15:0] bfv,
                       input logic [15:0] sv, input logic miv, input logic civ);
      logic [15:0] exp_rd;
      logic [3:0]  exp_p;
      string       tag;
      wr = w; rd = r; addr = a; wdata = d;
      rx_s = rxv; tx_s = txv; bf_s = bfv; st = sv; mi = miv; ci = civ;
      exp_rd = r ? m_read(a, sv) : 16'h0;
      tag    = r ? rd_tag(a) : "R9 idle read data";
      exp_p  = {w && d[6] && a == 2, w && d[6] && a == 4, w && d[6] && a == 3, w && d[6] && a == 0};
      if (w && a <= 4) m_cfg[a] = (a == 1) ? d : (d & 16'hFFBF);
      for (int k = 0; k < 3; k++)
         m_evt[k] = ((r && a == 5 + k) ? 16'h0 : m_evt[k]) | (k == 0 ? rxv : (k == 1 ? txv : bfv));
      for (int c = 0; c < 2; c++) begin
         logic inc;
         inc = (c == 0) ? miv : civ;
         if (r && a == 9 + c)             m_cnt[c] = inc ? 16'h1 : 16'h0;
         else if (inc && m_cnt[c] != '1)  m_cnt[c] = m_cnt[c] + 16'h1;
      end
      @(posedge clk);
      @(negedge clk);
      chk(rdata === exp_rd, tag, rdata, exp_rd);
      chk({p_swi, p_dma, p_srst, p_skip} === exp_p, "R5 action pulses",
          {12'h0, p_swi, p_dma, p_srst, p_skip}, {12'h0, exp_p});
      chk(irq === m_irq(), "R4 irq level", {15'h0, irq}, {15'h0, m_irq()});
   endtask

   task automatic rd_reg(input logic [3:0] a);
      step(1'b0, 1'b1, a, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0);
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
      step(1'b1, 1'b0, a, d, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'h1, 16'h0);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      for (int i = 0; i < 5; i++) m_cfg[i] = '0;
      for (int i = 0; i < 3; i++) m_evt[i] = '0;
      for (int i = 0; i < 2; i++) m_cnt[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R9 reset state
      chk(rdata === 16'h0, "R9 reset rdata", rdata, 16'h0);
      chk({p_swi, p_dma, p_srst, p_skip, irq} === 5'b0, "R9 reset outputs",
          {11'h0, p_swi, p_dma, p_srst, p_skip, irq}, 16'h0);
      for (int a = 0; a < 16; a++)
         step(1'b0, 1'b1, 4'(a), 16'h0, 16'h0, 16'h0, 16'h0, 16'hA5C3, 1'b0, 1'b0);

      // R1 / R5 trigger bits read back as zero
      wr_reg(4'd0, 16'hFFFF);
      rd_reg(4'd0);
      chk(rdata === 16'hFFBF, "R1 trigger bit masked", rdata, 16'hFFBF);
      wr_reg(4'd1, 16'h0040);
      rd_reg(4'd1);
      chk(rdata === 16'h0040, "R1 transmit cfg keeps bit 6", rdata, 16'h0040);
      wr_reg(4'd3, 16'h0040);
      chk(p_srst === 1'b1, "R5 soft reset pulse", {15'h0, p_srst}, 16'h1);
      rd_reg(4'd3);
      chk(p_srst === 1'b0, "R5 pulse lasts one cycle", {15'h0, p_srst}, 16'h0);

      // R6 writes to read-only registers ignored
      wr_reg(4'd6, 16'hFFFF);
      wr_reg(4'd9, 16'hFFFF);
      rd_reg(4'd6);
      chk(rdata === 16'h0, "R6 event write ignored", rdata, 16'h0);
      rd_reg(4'd9);
      chk(rdata === 16'h0, "R6 counter write ignored", rdata, 16'h0);

      // R2 / R4 event latches without enable, irq only with enable
      step(1'b0, 1'b0, 4'd0, 16'h0, 16'h0, 16'h0, 16'h0004, 16'h0, 1'b0, 1'b0);
      chk(irq === 1'b0, "R4 no irq without enable", {15'h0, irq}, 16'h0);
      wr_reg(4'd2, 16'h0004);
      chk(irq === 1'b1, "R4 irq once enabled", {15'h0, irq}, 16'h1);
      rd_reg(4'd7);
      chk(rdata === 16'h0004, "R2 event latched", rdata, 16'h0004);
      chk(irq === 1'b0, "R4 irq drops after read", {15'h0, irq}, 16'h0);

      // R3 strobe coinciding with clearing read
      step(1'b0, 1'b1, 4'd6, 16'h0, 16'h0, 16'h0008, 16'h0, 16'h0, 1'b0, 1'b0);
      rd_reg(4'd6);
      chk(rdata === 16'h0008, "R3 strobe survives clear", rdata, 16'h0008);

      // R8 count strobe coinciding with clearing read
      step(1'b0, 1'b0, 4'd0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b0);
      step(1'b0, 1'b0, 4'd0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b0);
      step(1'b0, 1'b1, 4'd9, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b1, 1'b0);
      chk(rdata === 16'h0002, "R7 count value", rdata, 16'h0002);
      rd_reg(4'd9);
      chk(rdata === 16'h0001, "R8 count during clear", rdata, 16'h0001);

      // R7 saturation
      rd_reg(4'd10);
      for (int i = 0; i < 65540; i++)
         step(1'b0, 1'b0, 4'd15, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b1);
      rd_reg(4'd10);
      chk(rdata === 16'hFFFF, "R7 saturates", rdata, 16'hFFFF);
      rd_reg(4'd10);
      chk(rdata === 16'h0000, "R7 cleared by read", rdata, 16'h0);

      // constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         logic r, w;
         r = ($urandom % 2) == 0;
         w = ($urandom % 4) == 0;
         step(w, r, 4'($urandom), 16'($urandom),
              16'($urandom & $urandom & $urandom), 16'($urandom & $urandom & $urandom),
              16'($urandom & $urandom & $urandom), 16'($urandom),
              ($urandom % 4) == 0, ($urandom % 4) == 0);
      end

      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule